// File: doc/BRIEF.md
# AUX Reply Timeout Encoder

This block turns a requested reply timeout, given in microseconds, into the compact setting that a reply-timeout counter uses. The setting has a 7-bit length and a 2-bit multiplier. The multiplier selects a unit of 8, 16, 32 or 64 microseconds, and the timeout equals length times unit. Coarser units are used only when a finer one cannot reach the request.

A load strobe with a 16-bit request updates the setting register. One cycle later an acknowledge pulse appears. In that same cycle the block returns the previous setting, converted back into microseconds, so a caller can save and later restore it.

A small down-counter is included to consume the setting. An arm strobe loads it with length times unit. Each microsecond tick then counts it down, and a timeout flag rises once the count is spent.

Top module: `aux_rx_timeout_enc`

## Requirements
- R1: After synchronous reset the setting is multiplier 0 with length 69, the acknowledge and timeout outputs are low, and the returned previous value is 0.
- R2: A load with a request of 0 selects the default setting of multiplier 0 and length 69.
- R3: A non-zero request selects the multiplier by threshold. Requests of 1016 us or less select 0 (8 us unit). Requests of 2032 us or less select 1 (16 us unit). Requests of 4064 us or less select 2 (32 us unit). Larger requests select 3 (64 us unit).
- R4: The length is the request divided by the selected unit, rounded up whenever a remainder is left, so a non-zero request never yields length 0.
- R5: A length that would exceed 127 is clamped to 127.
- R6: On each load the returned previous value equals the old length times the unit selected by the old multiplier, in microseconds.
- R7: The acknowledge output is high for exactly the one cycle after a load strobe, with the new setting and the previous value valid in that cycle. Without a load, the setting and the previous value hold.
- R8: An arm strobe loads the counter with length times unit of the current setting and clears the timeout flag. The flag rises one cycle after that many ticks have been counted and stays high until the next arm. Ticks given before that number is reached do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Strobe: take req_us_i as the new timeout request |
| req_us_i | input | 16 | Requested timeout in microseconds |
| arm_i | input | 1 | Strobe: start the timeout counter from the current setting |
| tick_us_i | input | 1 | One-cycle pulse per elapsed microsecond |
| len_o | output | 7 | Current length field |
| mult_o | output | 2 | Current multiplier (unit = 8 << mult_o us) |
| prev_us_o | output | 16 | Previous setting decoded to microseconds |
| ack_o | output | 1 | One-cycle acknowledge of a load |
| timeout_o | output | 1 | Counter has expired; held until the next arm |

## Verification
The assertions check, on every cycle, the handshake and hold behaviour: the acknowledge follows each strobe and lasts one cycle, the setting stays stable between loads, the length is never zero, and the returned value is always a whole number of 8 us units. They also check that the timeout flag stays set until an arm clears it, and that it is never set while the counter is still armed. The numeric mapping can only be shown by the bench scenarios, because it depends on the actual request values. That covers the threshold edges at 1016, 2032 and 4064 us and the value just above each, rounding up, clamping on very large requests, and the exact tick on which the counter expires.

// File: rtl/aux_tmo_pkg.sv
package aux_tmo_pkg;
  localparam int REQ_W_D      = 16;
  localparam int LEN_W_D      = 7;
  localparam int MULT_W_D     = 2;
  localparam int BASE_SHIFT_D = 3;
  localparam int STEP_US_D    = 1016;
  localparam int DEF_LEN_D    = 69;
endpackage

// File: rtl/aux_tmo_enc.sv
module aux_tmo_enc #(
  parameter int REQ_W      = aux_tmo_pkg::REQ_W_D,
  parameter int LEN_W      = aux_tmo_pkg::LEN_W_D,
  parameter int MULT_W     = aux_tmo_pkg::MULT_W_D,
  parameter int BASE_SHIFT = aux_tmo_pkg::BASE_SHIFT_D,
  parameter int STEP_US    = aux_tmo_pkg::STEP_US_D,
  parameter int DEF_LEN    = aux_tmo_pkg::DEF_LEN_D
) (
  input  logic [REQ_W-1:0]  req_us,
  output logic [LEN_W-1:0]  enc_len,
  output logic [MULT_W-1:0] enc_mult
);
  localparam int LEVELS  = 1 << MULT_W;
  localparam int LEN_MAX = (1 << LEN_W) - 1;

  logic [REQ_W-1:0]  cand [LEVELS];
  logic [LEVELS-1:0] fits;
  logic [MULT_W-1:0] sel;
  logic [REQ_W-1:0]  chosen;

  // One candidate per granularity: shift, then round up from the dropped bits.
  for (genvar g = 0; g < LEVELS; g++) begin : g_level
    localparam int SH = BASE_SHIFT + g;
    localparam logic [REQ_W:0] THR = (REQ_W+1)'(STEP_US) << g;
    logic [REQ_W-1:0] dropped;
    assign dropped  = req_us & REQ_W'((1 << SH) - 1);
    assign cand[g]  = (req_us >> SH) + REQ_W'(|dropped);
    assign fits[g]  = ({1'b0, req_us} <= THR);
  end

  // Finest level that still fits wins; the last level is the fallback.
  always_comb begin
    sel = MULT_W'(LEVELS - 1);
    for (int m = LEVELS - 2; m >= 0; m--) begin
      if (fits[m]) sel = MULT_W'(m);
    end
  end

  assign chosen = cand[sel];

  always_comb begin
    if (req_us == '0) begin
      enc_mult = '0;
      enc_len  = LEN_W'(DEF_LEN);
    end else begin
      enc_mult = sel;
      enc_len  = (chosen > REQ_W'(LEN_MAX)) ? LEN_W'(LEN_MAX) : chosen[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/aux_tmo_reg.sv
module aux_tmo_reg #(
  parameter int REQ_W      = aux_tmo_pkg::REQ_W_D,
  parameter int LEN_W      = aux_tmo_pkg::LEN_W_D,
  parameter int MULT_W     = aux_tmo_pkg::MULT_W_D,
  parameter int BASE_SHIFT = aux_tmo_pkg::BASE_SHIFT_D,
  parameter int DEF_LEN    = aux_tmo_pkg::DEF_LEN_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LEN_W-1:0]  new_len,
  input  logic [MULT_W-1:0] new_mult,
  output logic [LEN_W-1:0]  len_q,
  output logic [MULT_W-1:0] mult_q,
  output logic [REQ_W-1:0]  prev_q,
  output logic              ack_q
);
  logic [REQ_W-1:0] old_us;

  // Decode of the setting being replaced.
  assign old_us = REQ_W'(len_q) << (int'(mult_q) + BASE_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= LEN_W'(DEF_LEN);
      mult_q <= '0;
      prev_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= load;
      if (load) begin
        len_q  <= new_len;
        mult_q <= new_mult;
        prev_q <= old_us;
      end
    end
  end

  p_ack_follows_load_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> ack_q);
  p_ack_single_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> !ack_q);
  p_hold_setting_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(len_q) && $stable(mult_q) && $stable(prev_q)));
  p_len_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    len_q != '0);
  p_prev_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> ((prev_q & REQ_W'((1 << BASE_SHIFT) - 1)) == '0));
endmodule

// File: rtl/aux_tmo_cnt.sv
module aux_tmo_cnt #(
  parameter int REQ_W = aux_tmo_pkg::REQ_W_D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             tick,
  input  logic [REQ_W-1:0] start_us,
  output logic             expired
);
  logic [REQ_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      expired <= 1'b0;
    end else if (arm) begin
      cnt_q   <= start_us;
      armed_q <= 1'b1;
      expired <= 1'b0;
    end else if (armed_q) begin
      if (cnt_q == '0) begin
        expired <= 1'b1;
        armed_q <= 1'b0;
      end else if (tick) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  p_expired_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (expired && !arm) |=> expired);
  p_arm_clears_r8: assert property (@(posedge clk) disable iff (rst)
    arm |=> !expired);
  p_not_both_r8: assert property (@(posedge clk) disable iff (rst)
    !(armed_q && expired));
  p_no_tick_no_count_r8: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !arm && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/aux_rx_timeout_enc.sv
module aux_rx_timeout_enc #(
  parameter int REQ_W      = aux_tmo_pkg::REQ_W_D,
  parameter int LEN_W      = aux_tmo_pkg::LEN_W_D,
  parameter int MULT_W     = aux_tmo_pkg::MULT_W_D,
  parameter int BASE_SHIFT = aux_tmo_pkg::BASE_SHIFT_D,
  parameter int STEP_US    = aux_tmo_pkg::STEP_US_D,
  parameter int DEF_LEN    = aux_tmo_pkg::DEF_LEN_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [REQ_W-1:0]  req_us_i,
  input  logic              arm_i,
  input  logic              tick_us_i,
  output logic [LEN_W-1:0]  len_o,
  output logic [MULT_W-1:0] mult_o,
  output logic [REQ_W-1:0]  prev_us_o,
  output logic              ack_o,
  output logic              timeout_o
);
  logic [LEN_W-1:0]  enc_len;
  logic [MULT_W-1:0] enc_mult;
  logic [REQ_W-1:0]  start_us;

  aux_tmo_enc #(
    .REQ_W(REQ_W), .LEN_W(LEN_W), .MULT_W(MULT_W),
    .BASE_SHIFT(BASE_SHIFT), .STEP_US(STEP_US), .DEF_LEN(DEF_LEN)
  ) u_enc (
    .req_us(req_us_i), .enc_len(enc_len), .enc_mult(enc_mult)
  );

  aux_tmo_reg #(
    .REQ_W(REQ_W), .LEN_W(LEN_W), .MULT_W(MULT_W),
    .BASE_SHIFT(BASE_SHIFT), .DEF_LEN(DEF_LEN)
  ) u_reg (
    .clk(clk), .rst(rst), .load(load_i),
    .new_len(enc_len), .new_mult(enc_mult),
    .len_q(len_o), .mult_q(mult_o), .prev_q(prev_us_o), .ack_q(ack_o)
  );

  assign start_us = REQ_W'(len_o) << (int'(mult_o) + BASE_SHIFT);

  aux_tmo_cnt #(.REQ_W(REQ_W)) u_cnt (
    .clk(clk), .rst(rst), .arm(arm_i), .tick(tick_us_i),
    .start_us(start_us), .expired(timeout_o)
  );

  p_zero_req_default_r2: assert property (@(posedge clk) disable iff (rst)
    (load_i && req_us_i == '0) |=> (mult_o == '0 && len_o == LEN_W'(DEF_LEN)));
  p_fine_unit_small_r3: assert property (@(posedge clk) disable iff (rst)
    (load_i && req_us_i != '0 && req_us_i <= REQ_W'(STEP_US)) |=> (mult_o == '0));
endmodule

// File: tb/tb_aux_rx_timeout_enc.sv
module tb_aux_rx_timeout_enc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_i = 1'b0;
  logic [15:0] req_us_i = '0;
  logic        arm_i = 1'b0;
  logic        tick_us_i = 1'b0;
  logic [6:0]  len_o;
  logic [1:0]  mult_o;
  logic [15:0] prev_us_o;
  logic        ack_o;
  logic        timeout_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct { int len; int mult; int prev; } exp_t;
  exp_t sb_q[$];
  int cur_len  = 69;
  int cur_mult = 0;

  always #2 clk = ~clk;

  aux_rx_timeout_enc dut (
    .clk(clk), .rst(rst), .load_i(load_i), .req_us_i(req_us_i),
    .arm_i(arm_i), .tick_us_i(tick_us_i), .len_o(len_o), .mult_o(mult_o),
    .prev_us_o(prev_us_o), .ack_o(ack_o), .timeout_o(timeout_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input int r, output int l, output int m);
    int u;
    if (r == 0) begin
      m = 0; l = 69;
    end else begin
      if (r <= 1016) m = 0;
      else if (r <= 2032) m = 1;
      else if (r <= 4064) m = 2;
      else m = 3;
      u = 8 << m;
      l = (r + u - 1) / u;
      if (l > 127) l = 127;
    end
  endfunction

  // Driver: push the expected result, then strobe the load.
  task automatic do_load(input int r, input string tag);
    exp_t e;
    int l, m;
    model(r, l, m);
    e.len = l; e.mult = m; e.prev = cur_len * (8 << cur_mult);
    sb_q.push_back(e);
    cur_len = l; cur_mult = m;
    req_us_i = 16'(r);
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    @(negedge clk);
    check({tag, " R7 ack low after one cycle"}, int'(ack_o), 0);
    check({tag, " R7 len held"}, int'(len_o), l);
  endtask

  // Monitor: pop and compare on every acknowledge.
  always @(negedge clk) begin
    if (!rst && ack_o) begin
      if (sb_q.size() == 0) begin
        check("R7 unexpected ack", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check("R3 multiplier", int'(mult_o), e.mult);
        check("R4 R5 length", int'(len_o), e.len);
        check("R6 previous value", int'(prev_us_o), e.prev);
      end
    end
  end

  task automatic run_timer(input int n, input string tag);
    arm_i = 1'b1;
    @(negedge clk);
    arm_i = 1'b0;
    check({tag, " R8 arm clears timeout"}, int'(timeout_o), 0);
    tick_us_i = 1'b1;
    repeat (n - 1) @(negedge clk);
    tick_us_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({tag, " R8 no timeout one tick early"}, int'(timeout_o), 0);
    tick_us_i = 1'b1;
    @(negedge clk);
    tick_us_i = 1'b0;
    @(negedge clk);
    check({tag, " R8 timeout after full count"}, int'(timeout_o), 1);
    repeat (3) @(negedge clk);
    check({tag, " R8 timeout held"}, int'(timeout_o), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset length", int'(len_o), 69);
    check("R1 reset multiplier", int'(mult_o), 0);
    check("R1 reset ack", int'(ack_o), 0);
    check("R1 reset prev", int'(prev_us_o), 0);
    check("R1 reset timeout", int'(timeout_o), 0);

    do_load(0, "R2 zero request");
    do_load(1016, "R3 top of unit 8");
    do_load(1017, "R3 above 1016");
    do_load(2032, "R3 top of unit 16");
    do_load(2033, "R3 above 2032");
    do_load(4064, "R3 top of unit 32");
    do_load(4065, "R3 above 4064");
    do_load(65535, "R5 clamp");
    do_load(9, "R4 round up");
    do_load(8, "R4 exact");
    do_load(0, "R2 back to default");
    // Back-to-back loads: each must still be acknowledged once.
    do_load(100, "R7 sequence a");
    do_load(300, "R7 sequence b");

    // Idle ticks with the counter unarmed must not raise the flag.
    tick_us_i = 1'b1;
    repeat (20) @(negedge clk);
    tick_us_i = 1'b0;
    @(negedge clk);
    check("R8 idle ticks ignored", int'(timeout_o), 0);

    do_load(16, "R8 setup short");
    run_timer(16, "short");
    do_load(1100, "R8 setup medium");
    run_timer(1104, "medium");

    repeat (2) @(negedge clk);
    check("R7 queue drained", sb_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule